// File: doc/BRIEF.md
# Integer Execution Unit for a 32-bit RISC Core

This block is the combinational integer stage of a 32-bit load/store processor. The decoder passes it the primary opcode, the function field and the two register operand values read for the instruction. It also passes the 16-bit immediate, the 5-bit constant shift count and the two candidate destination indices. In the same cycle the unit returns the result word, the index of the register to write, a write enable and a flag that requests an arithmetic-overflow exception.

It covers four kinds of register-register work: add and subtract in a trapping and a non-trapping flavour, bitwise logic, signed and unsigned less-than compares, and shifts by a constant or by a register-held count. It also covers the immediate forms of add, compare and logic, plus the instruction that loads a constant into the upper half of a word. An operation that traps on overflow drops its register write.

Top module: `risc_int_exec`

## Requirements
- R1: With opcode 0, function codes 0x20 and 0x22 return rs plus rt and rs minus rt, modulo 2^32.
- R2: Signed overflow on function 0x20, function 0x22 or opcode 0x08 raises `ovf_trap` and drops `wr_en` low, while `result` still carries the wrapped sum.
- R3: Function codes 0x21 and 0x23 and opcode 0x09 give the same sums as their trapping counterparts, and they hold `ovf_trap` low and `wr_en` high even when the sum wraps.
- R4: With opcode 0, function codes 0x24, 0x25, 0x26 and 0x27 return the bitwise AND, OR, XOR and NOR of rs and rt.
- R5: Function 0x2a returns 1 when rs is less than rt as signed numbers, and 0 otherwise. Function 0x2b does the same compare on unsigned numbers. For rs=1 and rt=0xFFFFFFFF these give 0 and 1.
- R6: Function codes 0x00 (left) and 0x02 (right, zero fill) shift rt by `shamt` and ignore rs. A count of 0 returns rt unchanged.
- R7: Function codes 0x04, 0x06 and 0x07 perform the left, logical-right and arithmetic-right shifts of rt by the count in rs bits 4:0. The upper bits of rs are ignored.
- R8: Function codes 0x03 and 0x07 shift right and fill each vacated high bit with bit 31 of rt.
- R9: Opcodes 0x08, 0x09, 0x0a and 0x0b sign-extend the immediate. Opcode 0x0a is a signed compare and 0x0b an unsigned compare of rs against the extended value.
- R10: Opcodes 0x0c, 0x0d and 0x0e zero-extend the immediate and return the AND, OR and XOR of rs with it.
- R11: Opcode 0x0f returns the immediate in bits 31:16 with bits 15:0 cleared.
- R12: `dst_num` equals `rd_num` for opcode 0 and `rt_num` for the immediate opcodes.
- R13: Any other opcode, and any opcode-0 function code not listed above, yields `wr_en`=0, `ovf_trap`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Primary opcode |
| fn_code | input | 6 | Function field, used when the opcode is 0 |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand; the shifted value for shifts |
| imm16 | input | 16 | Instruction immediate |
| shamt | input | 5 | Constant shift count |
| rt_num | input | 5 | rt register index |
| rd_num | input | 5 | rd register index |
| result | output | 32 | Computed result word |
| dst_num | output | 5 | Register index to write |
| wr_en | output | 1 | Register write enable |
| ovf_trap | output | 1 | Arithmetic-overflow exception request |

## Verification
The hardest conditions to reach are the overflow boundaries. A signed add or subtract overflows only when both operands share a sign and the result's sign flips, and random operands seldom land at the 0x7FFFFFFF/0x80000000 edges where this happens. The vector table therefore places operand pairs directly on those edges. Each pair is run through the trapping and the non-trapping encoding, with both the register form and the immediate form, so that suppression of the write is seen to depend only on the encoding. Variable shifts use an rs value whose upper bits are set, so that a shifter reading more than five bits of the count gives a wrong result.

// File: rtl/risc_exec_pkg.sv
// Package: shared encodings and the decoded control bundle for the
// integer execution unit. Assumes the 6-bit opcode/function layout.
package risc_exec_pkg;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_ADDIU = 6'h09;
    localparam logic [5:0] OP_SLTI  = 6'h0a;
    localparam logic [5:0] OP_SLTIU = 6'h0b;
    localparam logic [5:0] OP_ANDI  = 6'h0c;
    localparam logic [5:0] OP_ORI   = 6'h0d;
    localparam logic [5:0] OP_XORI  = 6'h0e;
    localparam logic [5:0] OP_LUI   = 6'h0f;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_SLLV = 6'h04;
    localparam logic [5:0] FN_SRLV = 6'h06;
    localparam logic [5:0] FN_SRAV = 6'h07;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2a;
    localparam logic [5:0] FN_SLTU = 6'h2b;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_SLTU, K_SLL, K_SRL, K_SRA, K_LUI
    } exec_kind_e;

    typedef struct packed {
        exec_kind_e kind;
        logic       use_imm;   // operand B is the extended immediate
        logic       imm_sign;  // sign-extend (else zero-extend)
        logic       var_amt;   // shift count comes from rs
        logic       trap;      // signed overflow raises an exception
        logic       valid;     // encoding is recognised
        logic       dst_rt;    // write rt index (else rd)
    } exec_ctrl_t;

endpackage

// File: rtl/exec_decode.sv
// Module: exec_decode
// Turns opcode and function field into the control bundle.
// Assumes: purely combinational; unknown encodings give K_NONE, valid=0.
module exec_decode
    import risc_exec_pkg::*;
(
    input  logic [5:0]  op_code,
    input  logic [5:0]  fn_code,
    output exec_ctrl_t  ctl
);

    // Purpose: map each supported encoding to its control settings.
    always_comb begin
        ctl = '{kind: K_NONE, use_imm: 1'b0, imm_sign: 1'b0, var_amt: 1'b0,
                trap: 1'b0, valid: 1'b0, dst_rt: 1'b0};
        if (op_code == OP_REG) begin
            ctl.valid = 1'b1;
            unique case (fn_code)
                FN_ADD:  begin ctl.kind = K_ADD; ctl.trap = 1'b1; end
                FN_ADDU: ctl.kind = K_ADD;
                FN_SUB:  begin ctl.kind = K_SUB; ctl.trap = 1'b1; end
                FN_SUBU: ctl.kind = K_SUB;
                FN_AND:  ctl.kind = K_AND;
                FN_OR:   ctl.kind = K_OR;
                FN_XOR:  ctl.kind = K_XOR;
                FN_NOR:  ctl.kind = K_NOR;
                FN_SLT:  ctl.kind = K_SLT;
                FN_SLTU: ctl.kind = K_SLTU;
                FN_SLL:  ctl.kind = K_SLL;
                FN_SRL:  ctl.kind = K_SRL;
                FN_SRA:  ctl.kind = K_SRA;
                FN_SLLV: begin ctl.kind = K_SLL; ctl.var_amt = 1'b1; end
                FN_SRLV: begin ctl.kind = K_SRL; ctl.var_amt = 1'b1; end
                FN_SRAV: begin ctl.kind = K_SRA; ctl.var_amt = 1'b1; end
                default: ctl.valid = 1'b0;
            endcase
        end else begin
            ctl.valid   = 1'b1;
            ctl.use_imm = 1'b1;
            ctl.dst_rt  = 1'b1;
            unique case (op_code)
                OP_ADDI:  begin ctl.kind = K_ADD;  ctl.imm_sign = 1'b1; ctl.trap = 1'b1; end
                OP_ADDIU: begin ctl.kind = K_ADD;  ctl.imm_sign = 1'b1; end
                OP_SLTI:  begin ctl.kind = K_SLT;  ctl.imm_sign = 1'b1; end
                OP_SLTIU: begin ctl.kind = K_SLTU; ctl.imm_sign = 1'b1; end
                OP_ANDI:  ctl.kind = K_AND;
                OP_ORI:   ctl.kind = K_OR;
                OP_XORI:  ctl.kind = K_XOR;
                OP_LUI:   ctl.kind = K_LUI;
                default:  ctl.valid = 1'b0;
            endcase
        end
    end

    // Purpose: an unrecognised encoding must never carry a live operation.
    always_comb begin
        if (!ctl.valid)
            a_r13_undef_is_idle: assert (ctl.kind == K_NONE && !ctl.trap)
                else $error("R13 undecoded encoding carries an operation");
    end

endmodule

// File: rtl/exec_addsub.sv
// Module: exec_addsub
// Shared adder/subtractor and magnitude comparators.
// Assumes: two's complement operands of W bits.
module exec_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt_signed,
    output logic         lt_unsigned
);

    logic [W-1:0] opb_eff;

    // Purpose: one adder serves both add and subtract (invert plus carry-in).
    always_comb begin
        opb_eff     = do_sub ? ~opb : opb;
        sum         = opa + opb_eff + {{(W-1){1'b0}}, do_sub};
        ovf         = (opa[W-1] == opb_eff[W-1]) && (sum[W-1] != opa[W-1]);
        lt_signed   = $signed(opa) < $signed(opb);
        lt_unsigned = opa < opb;
    end

endmodule

// File: rtl/exec_shifter.sv
// Module: exec_shifter
// Logarithmic barrel shifter: right shifts with zero or sign fill, and
// left shifts done by bit-reversing around the right-shift core.
// Assumes: W is a power of two; amt has log2(W) bits.
module exec_shifter #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic           to_left,
    input  logic           sign_fill,
    output logic [W-1:0]   dout
);

    logic [W-1:0] din_rev;
    logic [W-1:0] core_rev;
    logic [W-1:0] stg [SHW+1];
    logic         fill;

    // Purpose: fill bit is the sign only for an arithmetic right shift.
    always_comb fill = sign_fill & !to_left & din[W-1];

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign din_rev[i]  = din[W-1-i];
        assign core_rev[i] = stg[SHW][W-1-i];
    end

    assign stg[0] = to_left ? din_rev : din;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][W-1:STEP]} : stg[k];
    end

    assign dout = to_left ? core_rev : stg[SHW];

    // Purpose: arithmetic right shift of a negative value stays negative.
    always_comb begin
        if (sign_fill && !to_left && din[W-1])
            a_r8_sign_kept: assert (dout[W-1])
                else $error("R8 arithmetic shift lost the sign bit");
    end

endmodule

// File: rtl/risc_int_exec.sv
// Module: risc_int_exec (top)
// Combinational integer execution unit: decode, operand selection,
// adder, shifter and result multiplexer.
// Assumes: operand values are already read from the register file.
module risc_int_exec
    import risc_exec_pkg::*;
#(
    parameter int W    = 32,
    parameter int IMMW = 16,
    parameter int RIDX = 5,
    localparam int SHW = $clog2(W)
) (
    input  logic [5:0]      op_code,
    input  logic [5:0]      fn_code,
    input  logic [W-1:0]    rs_val,
    input  logic [W-1:0]    rt_val,
    input  logic [IMMW-1:0] imm16,
    input  logic [SHW-1:0]  shamt,
    input  logic [RIDX-1:0] rt_num,
    input  logic [RIDX-1:0] rd_num,
    output logic [W-1:0]    result,
    output logic [RIDX-1:0] dst_num,
    output logic            wr_en,
    output logic            ovf_trap
);

    exec_ctrl_t     ctl;
    logic [W-1:0]   imm_ext;
    logic [W-1:0]   opnd_b;
    logic [W-1:0]   sum;
    logic           ovf_raw;
    logic           lt_s;
    logic           lt_u;
    logic [SHW-1:0] sh_amt;
    logic [W-1:0]   sh_out;

    exec_decode u_dec (
        .op_code (op_code),
        .fn_code (fn_code),
        .ctl     (ctl)
    );

    // Purpose: extend the immediate and choose the second operand.
    always_comb begin
        imm_ext = ctl.imm_sign ? {{(W-IMMW){imm16[IMMW-1]}}, imm16}
                               : {{(W-IMMW){1'b0}}, imm16};
        opnd_b  = ctl.use_imm ? imm_ext : rt_val;
        sh_amt  = ctl.var_amt ? rs_val[SHW-1:0] : shamt;
    end

    exec_addsub #(.W(W)) u_add (
        .opa         (rs_val),
        .opb         (opnd_b),
        .do_sub      (ctl.kind == K_SUB),
        .sum         (sum),
        .ovf         (ovf_raw),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    exec_shifter #(.W(W)) u_shf (
        .din       (rt_val),
        .amt       (sh_amt),
        .to_left   (ctl.kind == K_SLL),
        .sign_fill (ctl.kind == K_SRA),
        .dout      (sh_out)
    );

    // Purpose: select the result word for the decoded operation.
    always_comb begin
        unique case (ctl.kind)
            K_ADD, K_SUB: result = sum;
            K_AND:        result = rs_val & opnd_b;
            K_OR:         result = rs_val | opnd_b;
            K_XOR:        result = rs_val ^ opnd_b;
            K_NOR:        result = ~(rs_val | opnd_b);
            K_SLT:        result = {{(W-1){1'b0}}, lt_s};
            K_SLTU:       result = {{(W-1){1'b0}}, lt_u};
            K_SLL, K_SRL, K_SRA: result = sh_out;
            K_LUI:        result = {imm16, {(W-IMMW){1'b0}}};
            default:      result = '0;
        endcase
    end

    // Purpose: write control, trap request and destination index.
    always_comb begin
        ovf_trap = ctl.valid & ctl.trap & ovf_raw;
        wr_en    = ctl.valid & !ovf_trap;
        dst_num  = ctl.dst_rt ? rt_num : rd_num;
    end

    // Purpose: guard write suppression, compare width and upper-load shape.
    always_comb begin
        if (ctl.trap && ctl.kind == K_ADD && rs_val[W-1] == opnd_b[W-1]
            && result[W-1] != rs_val[W-1])
            a_r2_no_write_on_overflow: assert (ovf_trap && !wr_en)
                else $error("R2 overflowed trapping add still writes");
        if (ctl.valid && !ctl.trap)
            a_r3_no_trap_unsigned: assert (!ovf_trap && wr_en)
                else $error("R3 non-trapping operation raised a trap");
        if (ctl.kind == K_SLT || ctl.kind == K_SLTU)
            a_r5_compare_is_bit: assert (result[W-1:1] == '0)
                else $error("R5 compare result wider than one bit");
        if (ctl.kind == K_LUI)
            a_r11_lui_low_clear: assert (result[W-IMMW-1:0] == '0)
                else $error("R11 upper-load left low bits set");
    end

endmodule

// File: tb/risc_int_exec_bench.sv
module risc_int_exec_bench;

    // Vector: {op, fn, rs, rt, imm, shamt, exp_result, exp_we, exp_ovf, req}
    localparam int VW = 6+6+32+32+16+5+32+1+1+4;
    localparam int NV = 31;
    localparam logic [VW-1:0] VEC [NV] = '{
        {6'h00,6'h20,32'h00000005,32'h00000007,16'h0000,5'd0,32'h0000000C,1'b1,1'b0,4'd1},  // R1 add
        {6'h00,6'h22,32'h00000003,32'h00000005,16'h0000,5'd0,32'hFFFFFFFE,1'b1,1'b0,4'd1},  // R1 sub
        {6'h00,6'h21,32'h7FFFFFFF,32'h00000001,16'h0000,5'd0,32'h80000000,1'b1,1'b0,4'd3},  // R3 addu wraps
        {6'h00,6'h23,32'h80000000,32'h00000001,16'h0000,5'd0,32'h7FFFFFFF,1'b1,1'b0,4'd3},  // R3 subu wraps
        {6'h00,6'h20,32'h7FFFFFFF,32'h00000001,16'h0000,5'd0,32'h80000000,1'b0,1'b1,4'd2},  // R2 add +ovf
        {6'h00,6'h22,32'h80000000,32'h00000001,16'h0000,5'd0,32'h7FFFFFFF,1'b0,1'b1,4'd2},  // R2 sub ovf
        {6'h00,6'h20,32'h80000000,32'h80000000,16'h0000,5'd0,32'h00000000,1'b0,1'b1,4'd2},  // R2 add -ovf
        {6'h00,6'h24,32'hABCD1234,32'hFFFF0000,16'h0000,5'd0,32'hABCD0000,1'b1,1'b0,4'd4},  // R4 and
        {6'h00,6'h25,32'hABCD1234,32'hFFFF0000,16'h0000,5'd0,32'hFFFF1234,1'b1,1'b0,4'd4},  // R4 or
        {6'h00,6'h26,32'hABCD1234,32'hFFFF0000,16'h0000,5'd0,32'h54321234,1'b1,1'b0,4'd4},  // R4 xor
        {6'h00,6'h27,32'hABCD1234,32'hFFFF0000,16'h0000,5'd0,32'h0000EDCB,1'b1,1'b0,4'd4},  // R4 nor
        {6'h00,6'h2a,32'h00000001,32'hFFFFFFFF,16'h0000,5'd0,32'h00000000,1'b1,1'b0,4'd5},  // R5 slt
        {6'h00,6'h2b,32'h00000001,32'hFFFFFFFF,16'h0000,5'd0,32'h00000001,1'b1,1'b0,4'd5},  // R5 sltu
        {6'h00,6'h00,32'hFFFFFFFF,32'hABCD1234,16'h0000,5'd8,32'hCD123400,1'b1,1'b0,4'd6},  // R6 sll
        {6'h00,6'h03,32'hFFFFFFFF,32'hABCD1234,16'h0000,5'd4,32'hFABCD123,1'b1,1'b0,4'd8},  // R8 sra
        {6'h00,6'h02,32'hFFFFFFFF,32'hABCD1234,16'h0000,5'd4,32'h0ABCD123,1'b1,1'b0,4'd6},  // R6 srl
        {6'h00,6'h06,32'h00000010,32'hABCD1234,16'h0000,5'd0,32'h0000ABCD,1'b1,1'b0,4'd7},  // R7 srlv
        {6'h00,6'h04,32'hFFFFFFE4,32'h0000000F,16'h0000,5'd1,32'h000000F0,1'b1,1'b0,4'd7},  // R7 sllv low5
        {6'h00,6'h07,32'h0000001F,32'h80000000,16'h0000,5'd0,32'hFFFFFFFF,1'b1,1'b0,4'd8},  // R8 srav
        {6'h09,6'h00,32'h0000000A,32'h00000000,16'hFFFF,5'd0,32'h00000009,1'b1,1'b0,4'd9},  // R9 addiu -1
        {6'h08,6'h00,32'h7FFFFFFF,32'h00000000,16'h0001,5'd0,32'h80000000,1'b0,1'b1,4'd2},  // R2 addi ovf
        {6'h0a,6'h00,32'hFFFFFFFE,32'h00000000,16'hFFFF,5'd0,32'h00000001,1'b1,1'b0,4'd9},  // R9 slti
        {6'h0b,6'h00,32'h00000005,32'h00000000,16'hFFFF,5'd0,32'h00000001,1'b1,1'b0,4'd9},  // R9 sltiu
        {6'h0c,6'h00,32'hFFFFFFFF,32'h00000000,16'h8000,5'd0,32'h00008000,1'b1,1'b0,4'd10}, // R10 andi
        {6'h0d,6'h00,32'h00000000,32'h00000000,16'hABCD,5'd0,32'h0000ABCD,1'b1,1'b0,4'd10}, // R10 ori
        {6'h0e,6'h00,32'hFFFF0000,32'h00000000,16'hFFFF,5'd0,32'hFFFFFFFF,1'b1,1'b0,4'd10}, // R10 xori
        {6'h0f,6'h00,32'h12345678,32'h00000000,16'hAC51,5'd0,32'hAC510000,1'b1,1'b0,4'd11}, // R11 lui
        {6'h00,6'h01,32'h7FFFFFFF,32'h00000001,16'h0000,5'd0,32'h00000000,1'b0,1'b0,4'd13}, // R13 bad fn
        {6'h3f,6'h20,32'h7FFFFFFF,32'h00000001,16'hFFFF,5'd0,32'h00000000,1'b0,1'b0,4'd13}, // R13 bad op
        {6'h09,6'h00,32'h7FFFFFFF,32'h00000000,16'h0001,5'd0,32'h80000000,1'b1,1'b0,4'd3},  // R3 addiu wraps
        {6'h00,6'h00,32'hFFFFFFFF,32'hABCD1234,16'h0000,5'd0,32'hABCD1234,1'b1,1'b0,4'd6}   // R6 count 0
    };

    logic        clk = 1'b0;
    logic [5:0]  op_code = '0;
    logic [5:0]  fn_code = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  shamt = '0;
    logic [4:0]  rt_num = '0;
    logic [4:0]  rd_num = '0;
    logic [31:0] result;
    logic [4:0]  dst_num;
    logic        wr_en;
    logic        ovf_trap;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    risc_int_exec u_risc_int_exec (
        .op_code (op_code), .fn_code (fn_code), .rs_val (rs_val), .rt_val (rt_val),
        .imm16 (imm16), .shamt (shamt), .rt_num (rt_num), .rd_num (rd_num),
        .result (result), .dst_num (dst_num), .wr_en (wr_en), .ovf_trap (ovf_trap)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // Idle state: all-zero inputs decode as a zero-count left shift (R6).
        @(negedge clk);
        #1;
        check(6, "idle result", result, 32'h0);
        check(6, "idle write", {31'b0, wr_en}, 32'h1);
        check(2, "idle trap", {31'b0, ovf_trap}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            @(negedge clk);
            {op_code, fn_code, rs_val, rt_val, imm16, shamt} = v[VW-1:38];
            #1;
            check(int'(v[3:0]), $sformatf("vec%0d result", i), result, v[37:6]);
            check(int'(v[3:0]), $sformatf("vec%0d write", i), {31'b0, wr_en}, {31'b0, v[5]});
            check(int'(v[3:0]), $sformatf("vec%0d trap", i), {31'b0, ovf_trap}, {31'b0, v[4]});
        end

        // R12: destination index follows the format.
        @(negedge clk);
        rt_num = 5'd9; rd_num = 5'd17;
        op_code = 6'h00; fn_code = 6'h21; rs_val = 32'd1; rt_val = 32'd2;
        #1;
        check(12, "dst register form", {27'b0, dst_num}, 32'd17);
        @(negedge clk);
        op_code = 6'h0d; imm16 = 16'h0001;
        #1;
        check(12, "dst immediate form", {27'b0, dst_num}, 32'd9);

        // R2 boundary: just below overflow still writes.
        @(negedge clk);
        op_code = 6'h00; fn_code = 6'h20; rs_val = 32'h7FFFFFFE; rt_val = 32'h1;
        #1;
        check(2, "edge add no ovf", {30'b0, wr_en, ovf_trap}, 32'h2);
        check(1, "edge add sum", result, 32'h7FFFFFFF);

        // R7: upper rs bits ignored for arithmetic variable shift.
        @(negedge clk);
        fn_code = 6'h07; rs_val = 32'hFFFFFF08; rt_val = 32'h80001234;
        #1;
        check(7, "srav low five bits", result, 32'hFF800012);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule